// File: doc/BRIEF.md
# Header-Driven Route Lookup Stage

This stage sits at the front of a switch input port. For each packet it decides which output port the packet leaves on, using only the packet's header flit, and it rewrites that header so the next switch along the path can make its own decision. Body and tail flits are not decoded. They follow with the port chosen for their header and leave with their data unchanged.

A static mode input selects one of two routing schemes. In source-routed mode the source node places a list of output-port selects in the header. This stage takes the lowest select as its output port. It then shifts the remaining selects down by one slot and zero-fills the slot that is left empty at the top.

In table-driven mode the header carries a small routing index. A local table, loaded through a write port, returns both an output port and a next-hop index for that routing index. The next-hop index replaces the old one in the forwarded header.

The result is held in one output register on a valid/ready stream. Upstream is stalled while that register is full and downstream is not ready.

Top module: `route_lookup`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and every table entry reads as port 0 and next index 0.
- R2: Flit kind is two bits: bit 0 marks a header and bit 1 marks a tail. A body flit is 00, and 11 is a single-flit packet. In source-routed mode (`route_mode` = 0) a header leaves on the port given by `in_data[PORT_W-1:0]`.
- R3: In source-routed mode the select field `in_data[PORT_W*SEL_CNT-1:0]` is shifted right by `PORT_W`. The top `PORT_W` bits of the field become zero, and the data bits above the field are unchanged.
- R4: In table-driven mode (`route_mode` = 1) a header's index is `in_data[IDX_W-1:0]`, and the header leaves on the port stored in that table entry.
- R5: In table-driven mode the forwarded header has its index bits replaced by the entry's next index. All other bits are unchanged.
- R6: A flit without the header bit keeps its data unchanged. It leaves on the port chosen for the most recent header, regardless of the mode or of its own data.
- R7: A flit accepted on a rising edge (`in_valid` and `in_ready`) is on the output after that same edge, so the stage has one cycle of latency. With no new input and `out_ready` high, `out_valid` drops after the next edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_kind`, `out_data` and `out_port` hold their values.
- R9: With `tbl_we` high on an edge, entry `tbl_addr` takes `tbl_port` and `tbl_next`. A header looked up on the same edge sees the entry's old contents, and the new contents apply from the next edge.
- R10: `route_mode` affects only how headers are decoded and rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| route_mode | input | 1 | 0 source-routed, 1 table-driven |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Stage can accept a flit |
| in_kind | input | 2 | Bit 0 header, bit 1 tail |
| in_data | input | DATA_W | Input flit payload |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream accepts the flit |
| out_kind | output | 2 | Kind of the output flit |
| out_data | output | DATA_W | Output payload, header rewritten |
| out_port | output | PORT_W | Chosen output port |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | IDX_W | Table entry written |
| tbl_port | input | PORT_W | Output port stored in the entry |
| tbl_next | input | IDX_W | Next-hop index stored in the entry |

## Verification
Every routing result appears after the rising edge that accepts its flit. The bench drives inputs and reads outputs on falling edges, so each check lands half a cycle after the edge that produced the result.

A table write takes effect on its own edge but is seen only by lookups on later edges. The bench probes that boundary with a write and a lookup on the same edge, followed by a second lookup.

For stalls, the outputs are read on two falling edges in a row while downstream is held not ready. A third read follows the edge that releases the stall and loads the waiting flit.

// File: rtl/rlk_pkg.sv
package rlk_pkg;
  localparam int KIND_W = 2;
  localparam int HEAD_BIT = 0;
  localparam int TAIL_BIT = 1;
  typedef enum logic { MODE_SOURCE = 1'b0, MODE_TABLE = 1'b1 } route_mode_e;
endpackage

// File: rtl/rlk_src_strip.sv
module rlk_src_strip #(
  parameter int DATA_W  = 32,
  parameter int PORT_W  = 3,
  parameter int SEL_CNT = 4
) (
  input  logic [DATA_W-1:0] hdr_in,
  output logic [PORT_W-1:0] lead_port,
  output logic [DATA_W-1:0] hdr_out
);
  localparam int FIELD_W = PORT_W * SEL_CNT;

  function automatic logic [DATA_W-1:0] field_mask();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < FIELD_W);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] pop_select(input logic [DATA_W-1:0] h);
    logic [DATA_W-1:0] m;
    m = field_mask();
    return (h & ~m) | (((h & m) >> PORT_W) & m);
  endfunction

  assign lead_port = hdr_in[PORT_W-1:0];
  assign hdr_out   = pop_select(hdr_in);

  always_comb begin
    a_r3_top_slot_cleared: assert (hdr_out[FIELD_W-1 -: PORT_W] == '0);
  end
endmodule

// File: rtl/rlk_route_table.sv
module rlk_route_table #(
  parameter int PORT_W = 3,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [IDX_W-1:0]  wr_next,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PORT_W-1:0] rd_port,
  output logic [IDX_W-1:0]  rd_next
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int ENTRY_W = PORT_W + IDX_W;

  logic [ENTRY_W-1:0] entry_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n)   entry_q[e] <= '0;
      else if (hit) entry_q[e] <= {wr_port, wr_next};
    end
  end

  assign {rd_port, rd_next} = entry_q[rd_idx];

  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> entry_q[$past(wr_addr)] == {$past(wr_port), $past(wr_next)});
endmodule

// File: rtl/rlk_out_stage.sv
module rlk_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_bits,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_bits
);
  logic         valid_q;
  logic [W-1:0] bits_q;

  assign up_ready = !valid_q || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bits_q  <= '0;
    end else if (up_ready) begin
      valid_q <= up_valid;
      if (up_valid) bits_q <= up_bits;
    end
  end

  assign dn_valid = valid_q;
  assign dn_bits  = bits_q;

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_bits));
  a_r8_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |-> !up_ready);
endmodule

// File: rtl/route_lookup.sv
module route_lookup
  import rlk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PORT_W  = 3,
  parameter int SEL_CNT = 4,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              route_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [DATA_W-1:0] out_data,
  output logic [PORT_W-1:0] out_port,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [PORT_W-1:0] tbl_port,
  input  logic [IDX_W-1:0]  tbl_next
);
  localparam int STAGE_W = KIND_W + DATA_W + PORT_W;

  function automatic logic [DATA_W-1:0] swap_index(input logic [DATA_W-1:0] h,
                                                   input logic [IDX_W-1:0] nxt);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = (i < IDX_W) ? nxt[i] : h[i];
    return r;
  endfunction

  logic              fire, is_head;
  logic [PORT_W-1:0] src_port, tab_port, hold_port, port_d;
  logic [IDX_W-1:0]  tab_next;
  logic [DATA_W-1:0] src_hdr, tab_hdr, data_d;
  route_mode_e       mode;

  assign mode    = route_mode_e'(route_mode);
  assign fire    = in_valid && in_ready;
  assign is_head = in_kind[HEAD_BIT];

  rlk_src_strip #(.DATA_W(DATA_W), .PORT_W(PORT_W), .SEL_CNT(SEL_CNT)) u_strip (
    .hdr_in(in_data), .lead_port(src_port), .hdr_out(src_hdr));

  rlk_route_table #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
    .wr_port(tbl_port), .wr_next(tbl_next), .rd_idx(in_data[IDX_W-1:0]),
    .rd_port(tab_port), .rd_next(tab_next));

  assign tab_hdr = swap_index(in_data, tab_next);

  always_comb begin
    if (is_head) begin
      port_d = (mode == MODE_TABLE) ? tab_port : src_port;
      data_d = (mode == MODE_TABLE) ? tab_hdr  : src_hdr;
    end else begin
      port_d = hold_port;
      data_d = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                hold_port <= '0;
    else if (fire && is_head)  hold_port <= port_d;
  end

  rlk_out_stage #(.W(STAGE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .up_valid(in_valid), .up_ready(in_ready),
    .up_bits({in_kind, data_d, port_d}), .dn_valid(out_valid),
    .dn_ready(out_ready), .dn_bits({out_kind, out_data, out_port}));

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid && out_kind == $past(in_kind));
  a_r2_lead_select: assert property (@(posedge clk) disable iff (!rst_n)
    fire && is_head && mode == MODE_SOURCE |=> out_port == $past(in_data[PORT_W-1:0]));
  a_r4_table_port: assert property (@(posedge clk) disable iff (!rst_n)
    fire && is_head && mode == MODE_TABLE |=> out_port == $past(tab_port));
  a_r6_body_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !is_head |=> out_data == $past(in_data));
endmodule

// File: tb/route_lookup_test.sv
module route_lookup_test;
  localparam int DATA_W = 32;
  localparam int PORT_W = 3;
  localparam int IDX_W  = 4;
  localparam int NVEC   = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic route_mode = 1'b0, in_valid = 1'b0, out_ready = 1'b1, tbl_we = 1'b0;
  logic in_ready, out_valid;
  logic [1:0] in_kind = 2'b00, out_kind;
  logic [DATA_W-1:0] in_data = '0, out_data;
  logic [PORT_W-1:0] out_port, tbl_port = '0;
  logic [IDX_W-1:0] tbl_addr = '0, tbl_next = '0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  route_lookup uut (
    .clk(clk), .rst_n(rst_n), .route_mode(route_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_data(out_data), .out_port(out_port), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_port(tbl_port), .tbl_next(tbl_next));

  // {mode, kind, in_data, expected port, expected data}
  localparam logic [69:0] VEC [NVEC] = '{
    {1'b0, 2'b01, 32'hA5A503DD, 3'd5, 32'hA5A5007B},
    {1'b0, 2'b00, 32'hDEADBEEF, 3'd5, 32'hDEADBEEF},
    {1'b0, 2'b10, 32'h0BADF00D, 3'd5, 32'h0BADF00D},
    {1'b0, 2'b01, 32'h0000FFFF, 3'd7, 32'h0000F1FF},
    {1'b0, 2'b10, 32'h12345678, 3'd7, 32'h12345678},
    {1'b0, 2'b11, 32'h80000000, 3'd0, 32'h80000000},
    {1'b1, 2'b01, 32'hFFFFFFF5, 3'd6, 32'hFFFFFFF9},
    {1'b1, 2'b00, 32'h00000005, 3'd6, 32'h00000005},
    {1'b1, 2'b01, 32'h12340009, 3'd2, 32'h12340003},
    {1'b1, 2'b10, 32'hCAFEF00D, 3'd2, 32'hCAFEF00D},
    {1'b1, 2'b11, 32'h0000000F, 3'd7, 32'h00000000},
    {1'b1, 2'b01, 32'h77777773, 3'd0, 32'h77777770},
    {1'b0, 2'b00, 32'h00000001, 3'd0, 32'h00000001}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic m, input logic [1:0] k, input logic [DATA_W-1:0] d);
    @(negedge clk);
    route_mode = m; in_kind = k; in_data = d; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic write_entry(input logic [IDX_W-1:0] a, input logic [PORT_W-1:0] p,
                             input logic [IDX_W-1:0] n);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_port = p; tbl_next = n;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);

    write_entry(4'd5, 3'd6, 4'd9);
    write_entry(4'd9, 3'd2, 4'd3);
    write_entry(4'd15, 3'd7, 4'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [69:0] v;
      string req;
      v = VEC[i];
      if (!v[66]) req = "R6,R10";
      else if (v[69]) req = (i == 11) ? "R1,R4,R5" : "R4,R5";
      else req = "R2,R3";
      send(v[69], v[68:67], v[66:35]);
      check({req, " valid R7"}, 64'(out_valid), 64'd1);
      check({req, " kind"}, 64'(out_kind), 64'(v[68:67]));
      check({req, " port"}, 64'(out_port), 64'(v[34:32]));
      check({req, " data"}, 64'(out_data), 64'(v[31:0]));
    end

    // R7: with no new input the register drains after one edge
    @(negedge clk);
    check("R7 drain", 64'(out_valid), 64'd0);

    // R8: stall holds output and blocks input
    @(negedge clk);
    out_ready = 1'b0; route_mode = 1'b0; in_kind = 2'b00;
    in_data = 32'h11111111; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 first loaded", 64'(out_data), 64'h11111111);
    check("R8 in_ready low", 64'(in_ready), 64'd0);
    in_data = 32'h22222222;
    @(posedge clk);
    @(negedge clk);
    check("R8 data held", 64'(out_data), 64'h11111111);
    check("R8 valid held", 64'(out_valid), 64'd1);
    check("R8 still blocked", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second after release", 64'(out_data), 64'h22222222);

    // R9: lookup on the write edge sees old entry, next lookup sees new
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'd4; tbl_port = 3'd5; tbl_next = 4'd6;
    route_mode = 1'b1; in_kind = 2'b01; in_data = 32'h00000004; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0; in_valid = 1'b0;
    check("R9 same-edge port old", 64'(out_port), 64'd0);
    check("R9 same-edge data old", 64'(out_data), 64'd0);
    send(1'b1, 2'b01, 32'h00000004);
    check("R9 later port new", 64'(out_port), 64'd5);
    check("R9 later data new", 64'(out_data), 64'h00000006);

    // R3: field-only zero fill with selects in the top slot
    send(1'b0, 2'b01, 32'hFFFFFE3A);
    check("R2 lead select", 64'(out_port), 64'd2);
    check("R3 shifted field", 64'(out_data), 64'hFFFFF1C7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule